// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one instruction operand description into either a 32-bit effective address or an immediate operand value. A decoder that has already split the instruction presents a mode code, the contents of a base register and an index register, the current program counter, an extension word, a short signed displacement and an operand size code. It then pulses `start_i`. All direct modes return a registered result with a one-cycle `valid_o` pulse on the next clock edge.

Memory-indirect mode fetches a pointer word from memory through a simple request/acknowledge handshake. It returns that word as the effective address once the read is acknowledged. The post-increment and pre-decrement modes also return a pointer update value. The update is scaled by the operand size and flagged by `wb_en_o`, so the register file can write the stepped register back in the same cycle as the result.

Top module: `ea_unit`

## Requirements
- R1: After reset `valid_o`, `wb_en_o` and `mem_req_o` are low, and `result_o` is zero.
- R2: Mode 0 (immediate) returns `word_i` as the result. Mode 1 (register) returns `base_i` as the operand value. Neither mode raises `wb_en_o`.
- R3: Mode 2 (absolute) returns `word_i` as the address. Mode 3 (register-indirect) returns `base_i` as the address.
- R4: `disp_i` is a 16-bit two's-complement value and is sign-extended to 32 bits before any addition. Mode 5 (indexed) returns `base_i` + displacement, and the value of `index_i` has no effect.
- R5: Mode 6 returns `base_i` + `index_i`, and the value of `disp_i` has no effect. Mode 7 returns `base_i` + `index_i` + displacement.
- R6: Mode 8 (PC-relative) returns `pc_i` + displacement. A negative displacement gives an address below `pc_i`.
- R7: Mode 9 (post-increment) returns `base_i` as the address. It raises `wb_en_o` with `wb_val_o` = `base_i` + step.
- R8: Mode 10 (pre-decrement) returns `base_i` − step as the address. It raises `wb_en_o` with `wb_val_o` equal to that same value.
- R9: The step follows `size_i`: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R10: Every sum and difference wraps modulo 2^32, and no overflow indication exists.
- R11: For every mode other than 4, `valid_o` is high for exactly the one cycle after the edge that samples `start_i`, and `mem_req_o` stays low.
- R12: In mode 4 (memory-indirect), `mem_req_o` rises on the edge that samples `start_i`, with `mem_addr_o` = `word_i`. Both stay unchanged until an edge samples `mem_ack_i` high. On that edge `result_o` takes `mem_rdata_i`, `valid_o` pulses and `mem_req_o` drops.
- R13: A `start_i` that arrives while a memory-indirect read is pending is ignored. It produces no `valid_o` pulse and leaves the pending result unchanged.
- R14: Mode codes 11 to 15 are reserved. They give a `valid_o` pulse with `result_o` zero and `wb_en_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch one address computation |
| mode_i | input | 4 | Addressing mode code |
| size_i | input | 2 | Operand size code for the auto step |
| base_i | input | 32 | Base register contents |
| index_i | input | 32 | Index register contents |
| pc_i | input | 32 | Program counter |
| word_i | input | 32 | Extension word: constant, absolute address or pointer location |
| disp_i | input | 16 | Signed displacement |
| mem_req_o | output | 1 | Pointer read request |
| mem_addr_o | output | 32 | Pointer read address |
| mem_ack_i | input | 1 | Pointer read acknowledge |
| mem_rdata_i | input | 32 | Pointer word returned by memory |
| valid_o | output | 1 | Result strobe, one cycle |
| result_o | output | 32 | Effective address or operand value |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_val_o | output | 32 | Updated base register value |

## Verification
A wrong operand selection or a missing sign extension shows up as a wrong `result_o` in the cycle right after the start. The vector table exposes it because every row drives nonzero values into the fields that mode must ignore. A bad step or wrong decrement ordering is visible in that same cycle, either in `wb_val_o` or in a mismatch between `wb_val_o` and `result_o`. If the handshake state is corrupted, there are two symptoms. A request may drop before its acknowledge or change its address while waiting. Or a spurious or missing `valid_o` pulse appears one edge after the acknowledge or after an ignored start.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int MODE_W = 4;
    localparam int SIZE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM   = 4'd0,
        AM_REG   = 4'd1,
        AM_ABS   = 4'd2,
        AM_RIND  = 4'd3,
        AM_MIND  = 4'd4,
        AM_IDX   = 4'd5,
        AM_BX    = 4'd6,
        AM_BXD   = 4'd7,
        AM_REL   = 4'd8,
        AM_PINC  = 4'd9,
        AM_PDEC  = 4'd10
    } am_e;

    function automatic logic is_known(input logic [MODE_W-1:0] m);
        return m <= MODE_W'(AM_PDEC);
    endfunction

endpackage

// File: rtl/ea_sext.sv
module ea_sext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o
);
    generate
        if (OUT_W > IN_W) begin : g_ext
            assign val_o = {{(OUT_W-IN_W){val_i[IN_W-1]}}, val_i};
        end else begin : g_cut
            assign val_o = val_i[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ea_step.sv
module ea_step #(
    parameter int DW     = 32,
    parameter int SIZE_W = 2
) (
    input  logic [SIZE_W-1:0] size_i,
    output logic [DW-1:0]     step_o
);
    localparam int NSTEP = 1 << SIZE_W;

    generate
        for (genvar g = 0; g < DW; g++) begin : g_bit
            if (g < NSTEP) begin : g_live
                assign step_o[g] = (size_i == SIZE_W'(g));
            end else begin : g_zero
                assign step_o[g] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/ea_addgen.sv
module ea_addgen
    import ea_pkg::*;
#(
    parameter int DW     = 32,
    parameter int DISP_W = 16
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [DW-1:0]     base_i,
    input  logic [DW-1:0]     index_i,
    input  logic [DW-1:0]     pc_i,
    input  logic [DW-1:0]     word_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [DW-1:0]     res_o,
    output logic              wb_en_o,
    output logic [DW-1:0]     wb_val_o
);
    logic [DW-1:0] disp_x;
    logic [DW-1:0] step;
    logic [DW-1:0] op_a, op_b, op_c;
    logic [DW-1:0] sum;
    logic [DW-1:0] dec_val;

    ea_sext #(.IN_W(DISP_W), .OUT_W(DW)) u_sext (
        .val_i (disp_i),
        .val_o (disp_x)
    );

    ea_step #(.DW(DW), .SIZE_W(SIZE_W)) u_step (
        .size_i (size_i),
        .step_o (step)
    );

    // operand selection for the shared three-input adder
    always_comb begin
        op_a = '0;
        op_b = '0;
        op_c = '0;
        case (am_e'(mode_i))
            AM_IMM, AM_ABS: op_a = word_i;
            AM_REG, AM_RIND, AM_PINC: op_a = base_i;
            AM_IDX: begin
                op_a = base_i;
                op_c = disp_x;
            end
            AM_BX: begin
                op_a = base_i;
                op_b = index_i;
            end
            AM_BXD: begin
                op_a = base_i;
                op_b = index_i;
                op_c = disp_x;
            end
            AM_REL: begin
                op_a = pc_i;
                op_c = disp_x;
            end
            default: ;
        endcase
    end

    assign sum     = op_a + op_b + op_c;
    assign dec_val = base_i - step;

    always_comb begin
        res_o    = sum;
        wb_en_o  = 1'b0;
        wb_val_o = '0;
        case (am_e'(mode_i))
            AM_PINC: begin
                wb_en_o  = 1'b1;
                wb_val_o = base_i + step;
            end
            AM_PDEC: begin
                res_o    = dec_val;
                wb_en_o  = 1'b1;
                wb_val_o = dec_val;
            end
            default: ;
        endcase
        if (!is_known(mode_i)) begin
            res_o = '0;
        end
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int DW     = 32,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic [DW-1:0]     base_i,
    input  logic [DW-1:0]     index_i,
    input  logic [DW-1:0]     pc_i,
    input  logic [DW-1:0]     word_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic              mem_req_o,
    output logic [DW-1:0]     mem_addr_o,
    input  logic              mem_ack_i,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              valid_o,
    output logic [DW-1:0]     result_o,
    output logic              wb_en_o,
    output logic [DW-1:0]     wb_val_o
);
    typedef struct packed {
        logic              req;
        logic [DW-1:0]     maddr;
        logic              valid;
        logic [DW-1:0]     res;
        logic              wb_en;
        logic [DW-1:0]     wb_val;
        logic [MODE_W-1:0] mode;
    } st_t;

    st_t st_d, st_q;

    logic [DW-1:0] ag_res;
    logic          ag_wb_en;
    logic [DW-1:0] ag_wb_val;

    ea_addgen #(.DW(DW), .DISP_W(DISP_W)) u_addgen (
        .mode_i   (mode_i),
        .size_i   (size_i),
        .base_i   (base_i),
        .index_i  (index_i),
        .pc_i     (pc_i),
        .word_i   (word_i),
        .disp_i   (disp_i),
        .res_o    (ag_res),
        .wb_en_o  (ag_wb_en),
        .wb_val_o (ag_wb_val)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.wb_en = 1'b0;
        if (st_q.req) begin
            if (mem_ack_i) begin
                st_d.req   = 1'b0;
                st_d.valid = 1'b1;
                st_d.res   = mem_rdata_i;
            end
        end else if (start_i) begin
            st_d.mode = mode_i;
            if (am_e'(mode_i) == AM_MIND) begin
                st_d.req   = 1'b1;
                st_d.maddr = word_i;
            end else begin
                st_d.valid  = 1'b1;
                st_d.res    = ag_res;
                st_d.wb_en  = ag_wb_en;
                st_d.wb_val = ag_wb_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req_o  = st_q.req;
    assign mem_addr_o = st_q.maddr;
    assign valid_o    = st_q.valid;
    assign result_o   = st_q.res;
    assign wb_en_o    = st_q.wb_en;
    assign wb_val_o   = st_q.wb_val;

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

    // R12
    ack_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_ack_i |=> valid_o && !mem_req_o && result_o == $past(mem_rdata_i));

    // R11
    direct_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !mem_req_o && mode_i != 4'd4 |=> valid_o && !mem_req_o);

    // R13
    pending_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> !valid_o);

    // R8
    dec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && wb_en_o && st_q.mode == MODE_W'(AM_PDEC) |-> result_o == wb_val_o);

    // R7
    inc_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && wb_en_o && st_q.mode == MODE_W'(AM_PINC) |-> $countones(wb_val_o - result_o) == 1);

    // R14
    wb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> valid_o);
endmodule

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] base_i = '0, index_i = '0, pc_i = '0, word_i = '0;
    logic [15:0] disp_i = '0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        valid_o;
    logic [31:0] result_o;
    logic        wb_en_o;
    logic [31:0] wb_val_o;

    int total = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    ea_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .size_i(size_i), .base_i(base_i), .index_i(index_i), .pc_i(pc_i),
        .word_i(word_i), .disp_i(disp_i), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .valid_o(valid_o), .result_o(result_o),
        .wb_en_o(wb_en_o), .wb_val_o(wb_val_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  mode;
        logic [1:0]  size;
        logic [31:0] base;
        logic [31:0] index;
        logic [31:0] pc;
        logic [31:0] word;
        logic [15:0] disp;
        logic [31:0] eres;
        logic        ewb;
        logic [31:0] ewbv;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VTAB [NV] = '{
        '{4'd2,  4'd0,  2'd0, 32'h0000_1000, 32'h0000_0F00, 32'h0000_0800, 32'h1234_5678, 16'h0044, 32'h1234_5678, 1'b0, 32'h0}, // R2 imm
        '{4'd2,  4'd1,  2'd0, 32'hA5A5_0001, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'h0044, 32'hA5A5_0001, 1'b0, 32'h0}, // R2 reg
        '{4'd3,  4'd2,  2'd0, 32'h0000_1000, 32'h0000_0F00, 32'h0000_0800, 32'h0000_4000, 16'h0044, 32'h0000_4000, 1'b0, 32'h0}, // R3 abs
        '{4'd3,  4'd3,  2'd0, 32'h0000_2000, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'h0044, 32'h0000_2000, 1'b0, 32'h0}, // R3 rind
        '{4'd4,  4'd5,  2'd0, 32'h0000_1000, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'h0010, 32'h0000_1010, 1'b0, 32'h0}, // R4 +disp
        '{4'd4,  4'd5,  2'd0, 32'h0000_1000, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'hFFF0, 32'h0000_0FF0, 1'b0, 32'h0}, // R4 -disp
        '{4'd5,  4'd6,  2'd0, 32'h0000_1000, 32'h0000_0234, 32'h0000_0800, 32'h0000_7000, 16'h0044, 32'h0000_1234, 1'b0, 32'h0}, // R5 bx
        '{4'd5,  4'd7,  2'd0, 32'h0000_1000, 32'h0000_0200, 32'h0000_0800, 32'h0000_7000, 16'hFFFC, 32'h0000_11FC, 1'b0, 32'h0}, // R5 bxd
        '{4'd6,  4'd8,  2'd0, 32'h0000_1000, 32'h0000_0F00, 32'h0000_0100, 32'h0000_7000, 16'h0020, 32'h0000_0120, 1'b0, 32'h0}, // R6 fwd
        '{4'd6,  4'd8,  2'd0, 32'h0000_1000, 32'h0000_0F00, 32'h0000_0200, 32'h0000_7000, 16'hFF00, 32'h0000_0100, 1'b0, 32'h0}, // R6 back
        '{4'd7,  4'd9,  2'd0, 32'h0000_3000, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'h0044, 32'h0000_3000, 1'b1, 32'h0000_3001}, // R7 R9 byte
        '{4'd9,  4'd9,  2'd1, 32'h0000_3000, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'h0044, 32'h0000_3000, 1'b1, 32'h0000_3002}, // R9 half
        '{4'd8,  4'd10, 2'd2, 32'h0000_3000, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'h0044, 32'h0000_2FFC, 1'b1, 32'h0000_2FFC}, // R8 R9 word
        '{4'd9,  4'd10, 2'd3, 32'h0000_3000, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'h0044, 32'h0000_2FF8, 1'b1, 32'h0000_2FF8}, // R9 dword
        '{4'd10, 4'd5,  2'd0, 32'hFFFF_FFFE, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'h0005, 32'h0000_0003, 1'b0, 32'h0}, // R10 idx wrap
        '{4'd10, 4'd9,  2'd2, 32'hFFFF_FFFC, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'h0044, 32'hFFFF_FFFC, 1'b1, 32'h0000_0000}, // R10 inc wrap
        '{4'd10, 4'd10, 2'd0, 32'h0000_0000, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'h0044, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF}, // R10 dec wrap
        '{4'd14, 4'd13, 2'd0, 32'h0000_1000, 32'h0000_0F00, 32'h0000_0800, 32'h0000_7000, 16'h0044, 32'h0000_0000, 1'b0, 32'h0}  // R14 reserved
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            summary();
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'b0, valid_o}, 32'h0);
        chk("R1 wb_en", {31'b0, wb_en_o}, 32'h0);
        chk("R1 req", {31'b0, mem_req_o}, 32'h0);
        chk("R1 result", result_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            mode_i  = VTAB[i].mode;
            size_i  = VTAB[i].size;
            base_i  = VTAB[i].base;
            index_i = VTAB[i].index;
            pc_i    = VTAB[i].pc;
            word_i  = VTAB[i].word;
            disp_i  = VTAB[i].disp;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk($sformatf("R%0d v%0d result", VTAB[i].req, i), result_o, VTAB[i].eres);
            chk($sformatf("R%0d v%0d wb_en", VTAB[i].req, i), {31'b0, wb_en_o}, {31'b0, VTAB[i].ewb});
            if (VTAB[i].ewb)
                chk($sformatf("R%0d v%0d wb_val", VTAB[i].req, i), wb_val_o, VTAB[i].ewbv);
            // R11 pulse and no memory request on direct modes
            chk($sformatf("R11 v%0d valid", i), {31'b0, valid_o}, 32'h1);
            chk($sformatf("R11 v%0d req", i), {31'b0, mem_req_o}, 32'h0);
            @(negedge clk);
            chk($sformatf("R11 v%0d valid drop", i), {31'b0, valid_o}, 32'h0);
        end

        // R12 memory-indirect with wait states
        mode_i = 4'd4; word_i = 32'h0000_5000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        word_i = 32'h0000_6666;
        chk("R12 req up", {31'b0, mem_req_o}, 32'h1);
        chk("R12 addr", mem_addr_o, 32'h0000_5000);
        chk("R12 no valid yet", {31'b0, valid_o}, 32'h0);
        // R13 start while pending
        mode_i = 4'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R13 no valid", {31'b0, valid_o}, 32'h0);
        @(negedge clk);
        chk("R12 req held", {31'b0, mem_req_o}, 32'h1);
        chk("R12 addr held", mem_addr_o, 32'h0000_5000);
        mem_ack_i = 1'b1; mem_rdata_i = 32'h0000_9ABC;
        @(negedge clk);
        mem_ack_i = 1'b0; mem_rdata_i = 32'h0;
        chk("R12 valid", {31'b0, valid_o}, 32'h1);
        chk("R12 result", result_o, 32'h0000_9ABC);
        chk("R12 req drop", {31'b0, mem_req_o}, 32'h0);
        chk("R12 no wb", {31'b0, wb_en_o}, 32'h0);
        @(negedge clk);
        chk("R13 single valid", {31'b0, valid_o}, 32'h0);
        chk("R13 result kept", result_o, 32'h0000_9ABC);

        // R12 acknowledge in the first request cycle
        mode_i = 4'd4; word_i = 32'h0000_0040; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R12 fast addr", mem_addr_o, 32'h0000_0040);
        mem_ack_i = 1'b1; mem_rdata_i = 32'hDEAD_0008;
        @(negedge clk);
        mem_ack_i = 1'b0;
        chk("R12 fast valid", {31'b0, valid_o}, 32'h1);
        chk("R12 fast result", result_o, 32'hDEAD_0008);

        // R1 reset mid-flight
        mode_i = 4'd4; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1 req cleared", {31'b0, mem_req_o}, 32'h0);
        chk("R1 result cleared", result_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end
endmodule